// File: doc/BRIEF.md
# Masked Per-Port Event Counter Bank

This block holds one 16-bit statistics counter per port of a multi-port repeater hub. Each port presents a vector of already-qualified event flags, one per event category, and a single shared strobe marks the end of each packet repetition. At that strobe, every port that has at least one flag set in a category enabled by the shared mask register advances its counter by one. No processor action is needed for this.

A host reaches the block through a plain register port. It reads and writes each counter, and it programs the category mask and a control register. The control register holds clear-on-read, saturate-at-maximum and the three interrupt enables. Each counter decodes three value ranges: low, high and full. Each range is ORed across all ports. The ORed result can be read from a status register and drives the interrupt output when its enable is set. Event pulses are single-cycle flags with no handshake, because the block always accepts them. Host reads return data in the same cycle and never stall.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset every counter reads 0, the mask register and the control register read 0, and `irq` is low.
- R2: On a cycle with `pkt_end` high, a port's counter rises by exactly 1 if any of its category flags is set while the same mask bit is set. This holds even when several enabled flags are set. Flags in unmasked categories have no effect. Port p, category c is bit p*11+c of `port_evt`. The categories and their bits are: 0 jabber, 1 elasticity error, 2 lock loss, 3 missing frame delimiter, 4 late collision, 5 transmit collision, 6 receive collision, 7 partition, 8 link loss, 9 short event, 10 packet received. The mask sits at address 8, with bit c enabling category c.
- R3: Counter p is read and written at address p (p < 4). The read data equals the counter value in the same cycle. If a write and an increment fall in the same cycle, the written value is kept.
- R4: Control bit 0 (clear-on-read) at address 9 clears a counter on the clock edge that ends a host read of it. If that read coincides with an increment of the same counter, the counter becomes 1. With bit 0 clear, a read leaves the counter unchanged.
- R5: With control bit 1 clear, an increment from 0xFFFF yields 0x0000.
- R6: With control bit 1 (saturate) set, a counter at 0xFFFF stays at 0xFFFF on an increment.
- R7: Status register address 10 reads bit 0 set when any counter is <= 0x00FF, bit 1 set when any counter is >= 0xC000, and bit 2 set when any counter equals 0xFFFF.
- R8: `irq` is high exactly when some status bit n (n = 0,1,2) is set together with control bit n+2.
- R9: Category flags present while `pkt_end` is low change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_end | input | 1 | End-of-repetition strobe |
| port_evt | input | 44 | Qualified category flags, 11 per port |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, same cycle |
| irq | output | 1 | Threshold interrupt |

## Verification
The hardest states to reach are the ones where a host access and an end-of-packet increment land on the same counter in the same cycle. The stimulus aligns a write with a strobe, and separately a clear-on-read with a strobe, and then reads the counter back. The low-range status bit is asserted by any idle counter. To see it drop, the bench first writes every counter above 0x00FF, then moves one counter exactly onto each threshold boundary.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int NCAT = 11;
  localparam int EV_JAB    = 0;
  localparam int EV_ELAST  = 1;
  localparam int EV_LOCK   = 2;
  localparam int EV_NOSFD  = 3;
  localparam int EV_LATE   = 4;
  localparam int EV_TXCOL  = 5;
  localparam int EV_RXCOL  = 6;
  localparam int EV_PART   = 7;
  localparam int EV_LINK   = 8;
  localparam int EV_SHORT  = 9;
  localparam int EV_RXPKT  = 10;

  localparam int ADDR_MASK = 8;
  localparam int ADDR_CTRL = 9;
  localparam int ADDR_STAT = 10;

  typedef struct packed {
    logic en_full;
    logic en_high;
    logic en_low;
    logic sat;
    logic clr_rd;
  } ctrl_t;

  typedef struct packed {
    logic full;
    logic high;
    logic low;
  } dec_t;
endpackage

// File: rtl/evt_ctr_cell.sv
module evt_ctr_cell
  import evt_ctr_pkg::*;
#(
  parameter int CW       = 16,
  parameter int NC       = NCAT,
  parameter int LOW_LIM  = 16'h00FF,
  parameter int HIGH_LIM = 16'hC000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_end,
  input  logic [NC-1:0] evt,
  input  logic [NC-1:0] mask,
  input  logic          sat,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  input  logic          rd_clr,
  output logic [CW-1:0] cnt,
  output dec_t          dec
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam logic [CW-1:0] LOWV = CW'(LOW_LIM);
  localparam logic [CW-1:0] HIGV = CW'(HIGH_LIM);

  logic hit;
  assign hit = pkt_end && (|(evt & mask));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (wr_en)
      cnt <= wdata;
    else if (rd_clr)
      cnt <= hit ? CW'(1) : '0;
    else if (hit && !(sat && cnt == MAXV))
      cnt <= cnt + CW'(1);
  end

  always_comb begin
    dec.low  = (cnt <= LOWV);
    dec.high = (cnt >= HIGV);
    dec.full = (cnt == MAXV);
  end

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !wr_en && !rd_clr && cnt != MAXV |=> cnt == $past(cnt) + CW'(1));
  // R3
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wdata));
  // R4
  clear_keeps_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && hit && !wr_en |=> cnt == CW'(1));
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !sat && !wr_en && !rd_clr && cnt == MAXV |=> cnt == '0);
  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat && !wr_en && !rd_clr && cnt == MAXV |=> cnt == MAXV);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end && !wr_en && !rd_clr |=> $stable(cnt));
endmodule

// File: rtl/evt_ctr_regs.sv
module evt_ctr_regs
  import evt_ctr_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int CW    = 16,
  parameter int NC    = NCAT,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [AW-1:0]     host_addr,
  input  logic [CW-1:0]     host_wdata,
  input  logic [NPORT*CW-1:0] cnt_flat,
  input  dec_t              any_dec,
  output logic [NC-1:0]     mask,
  output ctrl_t             ctrl,
  output logic [CW-1:0]     host_rdata,
  output logic [NPORT-1:0]  ctr_wr,
  output logic [NPORT-1:0]  ctr_clr
);
  localparam int CTW = $bits(ctrl_t);
  localparam int DW  = $bits(dec_t);

  logic sel_mask, sel_ctrl, sel_stat;
  assign sel_mask = (host_addr == AW'(ADDR_MASK));
  assign sel_ctrl = (host_addr == AW'(ADDR_CTRL));
  assign sel_stat = (host_addr == AW'(ADDR_STAT));

  for (genvar p = 0; p < NPORT; p++) begin : g_sel
    assign ctr_wr[p]  = host_wr && (host_addr == AW'(p));
    assign ctr_clr[p] = host_rd && ctrl.clr_rd && (host_addr == AW'(p));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      ctrl <= '0;
    end else if (host_wr) begin
      if (sel_mask) mask <= host_wdata[NC-1:0];
      if (sel_ctrl) ctrl <= ctrl_t'(host_wdata[CTW-1:0]);
    end
  end

  always_comb begin
    host_rdata = '0;
    for (int p = 0; p < NPORT; p++)
      if (host_addr == AW'(p)) host_rdata = cnt_flat[p*CW +: CW];
    if (sel_mask) host_rdata[NC-1:0] = mask;
    if (sel_ctrl) host_rdata[CTW-1:0] = ctrl;
    if (sel_stat) host_rdata[DW-1:0] = any_dec;
  end

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && sel_mask |=> mask == $past(host_wdata[NC-1:0]));
  // R4
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctr_clr));
endmodule

// File: rtl/evt_ctr_irq.sv
module evt_ctr_irq
  import evt_ctr_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic [NPORT*$bits(dec_t)-1:0] dec_flat,
  input  ctrl_t                         ctrl,
  output dec_t                          any_dec,
  output logic                          irq
);
  localparam int DW = $bits(dec_t);

  for (genvar k = 0; k < DW; k++) begin : g_or
    logic [NPORT-1:0] col;
    for (genvar p = 0; p < NPORT; p++) begin : g_col
      assign col[p] = dec_flat[p*DW + k];
    end
    assign any_dec[k] = |col;
  end

  assign irq = (any_dec.low  && ctrl.en_low)  ||
               (any_dec.high && ctrl.en_high) ||
               (any_dec.full && ctrl.en_full);

  // R8
  always_comb begin
    quiet_irq_chk: assert (ctrl.en_low || ctrl.en_high || ctrl.en_full || !irq);
  end
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int NPORT    = 4,
  parameter int CW       = 16,
  parameter int AW       = 4,
  parameter int LOW_LIM  = 16'h00FF,
  parameter int HIGH_LIM = 16'hC000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_end,
  input  logic [NPORT*NCAT-1:0] port_evt,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [AW-1:0]         host_addr,
  input  logic [CW-1:0]         host_wdata,
  output logic [CW-1:0]         host_rdata,
  output logic                  irq
);
  localparam int DW = $bits(dec_t);

  logic [NCAT-1:0]     mask;
  ctrl_t               ctrl;
  logic [NPORT-1:0]    ctr_wr, ctr_clr;
  logic [NPORT*CW-1:0] cnt_flat;
  logic [NPORT*DW-1:0] dec_flat;
  dec_t                any_dec;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dec_t d;
    evt_ctr_cell #(.CW(CW), .NC(NCAT), .LOW_LIM(LOW_LIM), .HIGH_LIM(HIGH_LIM)) i_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .pkt_end(pkt_end),
      .evt    (port_evt[p*NCAT +: NCAT]),
      .mask   (mask),
      .sat    (ctrl.sat),
      .wr_en  (ctr_wr[p]),
      .wdata  (host_wdata),
      .rd_clr (ctr_clr[p]),
      .cnt    (cnt_flat[p*CW +: CW]),
      .dec    (d)
    );
    assign dec_flat[p*DW +: DW] = d;
  end

  evt_ctr_regs #(.NPORT(NPORT), .CW(CW), .NC(NCAT), .AW(AW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .cnt_flat  (cnt_flat),
    .any_dec   (any_dec),
    .mask      (mask),
    .ctrl      (ctrl),
    .host_rdata(host_rdata),
    .ctr_wr    (ctr_wr),
    .ctr_clr   (ctr_clr)
  );

  evt_ctr_irq #(.NPORT(NPORT)) i_irq (
    .dec_flat(dec_flat),
    .ctrl    (ctrl),
    .any_dec (any_dec),
    .irq     (irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !irq && mask == '0);
endmodule

// File: tb/test_evt_ctr_bank.sv
`timescale 1ns/1ps
module test_evt_ctr_bank;
  localparam int NP = 4;
  localparam int NC = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pkt_end = 1'b0;
  logic [NP*NC-1:0] port_evt = '0;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [3:0]    host_addr = '0;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       req_q[$];

  always #10 clk = ~clk;

  evt_ctr_bank i_evt_ctr_bank (
    .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .port_evt(port_evt),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (host_rd) begin
      if (exp_q.size() == 0) check(host_rdata, 16'hxxxx, "scoreboard");
      else check(host_rdata, exp_q.pop_front(), req_q.pop_front());
    end
  end

  function automatic logic [NP*NC-1:0] ev(input int p, input int c);
    logic [NP*NC-1:0] v = '0;
    v[p*NC + c] = 1'b1;
    return v;
  endfunction

  // driver: one cycle of stimulus, expected read value pushed when rd is set
  task automatic cyc(input bit wr, input bit rd, input int addr, input logic [15:0] wd,
                     input bit strobe, input logic [NP*NC-1:0] e,
                     input logic [15:0] exp, input string req);
    @(posedge clk); #1;
    host_wr = wr; host_rd = rd; host_addr = 4'(addr); host_wdata = wd;
    pkt_end = strobe; port_evt = e;
    if (rd) begin exp_q.push_back(exp); req_q.push_back(req); end
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; pkt_end = 0; port_evt = '0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    cyc(1, 0, a, d, 0, '0, '0, "");
  endtask
  task automatic rd(input int a, input logic [15:0] e, input string req);
    cyc(0, 1, a, '0, 0, '0, e, req);
  endtask
  task automatic strobe(input logic [NP*NC-1:0] e);
    cyc(0, 0, 0, '0, 1, e, '0, "");
  endtask
  task automatic irq_is(input logic e, input string req);
    @(negedge clk);
    check({15'd0, irq}, {15'd0, e}, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    irq_is(1'b0, "R1");
    for (int p = 0; p < NP; p++) rd(p, 16'h0000, "R1");
    rd(8, 16'h0000, "R1");
    rd(9, 16'h0000, "R1");
    // R2 mask: receive collision (6) and packet received (10)
    wr(8, 16'h0440);
    rd(8, 16'h0440, "R2");
    strobe(ev(0,10) | ev(1,10) | ev(1,6) | ev(2,0));
    rd(0, 16'h0001, "R2");
    rd(1, 16'h0001, "R2");
    rd(2, 16'h0000, "R2");
    rd(3, 16'h0000, "R2");
    // R9 flags without strobe
    cyc(0, 0, 0, '0, 0, ev(3,10), '0, "");
    rd(3, 16'h0000, "R9");
    // R3 write collides with increment
    cyc(1, 0, 2, 16'h1234, 1, ev(2,10), '0, "");
    rd(2, 16'h1234, "R3");
    // R4 clear-on-read
    wr(9, 16'h0001);
    rd(0, 16'h0001, "R4");
    rd(0, 16'h0000, "R4");
    cyc(0, 1, 1, '0, 1, ev(1,10), 16'h0001, "R4");
    rd(1, 16'h0001, "R4");
    rd(1, 16'h0000, "R4");
    wr(9, 16'h0000);
    rd(2, 16'h1234, "R4");
    rd(2, 16'h1234, "R4");
    // R7 all three ranges present
    wr(3, 16'hFFFF);
    rd(10, 16'h0007, "R7");
    // R5 wrap
    strobe(ev(3,6));
    rd(3, 16'h0000, "R5");
    // R6 saturate
    wr(9, 16'h0002);
    wr(3, 16'hFFFF);
    strobe(ev(3,10));
    rd(3, 16'hFFFF, "R6");
    // R8 interrupt enables
    irq_is(1'b0, "R8");
    wr(9, 16'h0012);
    irq_is(1'b1, "R8");
    wr(9, 16'h0008);
    irq_is(1'b1, "R8");
    wr(3, 16'hBFFF);
    irq_is(1'b0, "R8");
    rd(10, 16'h0001, "R7");
    wr(3, 16'hC000);
    rd(10, 16'h0003, "R7");
    wr(0, 16'h0100);
    wr(1, 16'h0100);
    wr(3, 16'h0100);
    rd(10, 16'h0000, "R7");
    wr(9, 16'h0004);
    irq_is(1'b0, "R8");
    wr(3, 16'h00FF);
    irq_is(1'b1, "R8");
    rd(10, 16'h0001, "R7");
    repeat (2) @(posedge clk);
    check(16'(exp_q.size()), 16'h0000, "scoreboard drained");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule